// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches an active-low interrupt pin driven from outside the chip and turns it into a latched interrupt request for the processor. The pin is first brought into the clock domain by a chain of flip-flops. A high-to-low change between two consecutive synchronised samples sets a request latch. The latch stays set until software clears it.

Software sees one 8-bit status/control register on a plain byte bus. The bus has an address, a write strobe, a read strobe, write data and read data. Through this register, software reads the pending flag, clears the latch by writing a one to a self-clearing acknowledge bit, masks the request toward the processor, and selects the sensitivity.

There are two sensitivities. In edge sensitivity, only falling edges set the latch. In level sensitivity, falling edges set the latch, and the latch is also held set for as long as the synchronised pin stays low. Because of that hold, an acknowledge issued while the pin is still low has no effect in level sensitivity.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the mask, the mode and the request latch are all 0. `cpu_irq` is 0, and a read of the register returns 8'h00.
- R2: A read with `bus_rd`=1 and `bus_addr`=REG_ADDR returns this layout: bits 7..4 = 0, bit 3 = request latch (pending), bit 2 = 0 (acknowledge always reads 0), bit 1 = mask, bit 0 = mode. In every other case `bus_rdata` is 8'h00.
- R3: A write with `bus_wr`=1 and `bus_addr`=REG_ADDR loads mask from `bus_wdata[1]` and mode from `bus_wdata[0]` at that clock edge. The new values take effect from the following cycle. `bus_wdata[7:3]` is ignored.
- R4: The pin passes through two synchronising flops. If the pin is first sampled low at clock edge k after being high, the pending flag reads 1 after clock edge k+2.
- R5: With mode = 0 (edge sensitivity), only a falling edge sets the latch. An acknowledge written while the pin stays low clears the latch, and the latch stays clear until the next falling edge.
- R6: A write with `bus_wdata[2]`=1 clears the latch, unless a set condition holds in the same cycle. A write with `bus_wdata[2]`=0 leaves the latch unchanged.
- R7: With mode = 1 (level sensitivity), the latch is set in every cycle in which the synchronised pin is low, so an acknowledge is ignored while the pin is low. Once the pin has returned high, an acknowledge clears the latch.
- R8: If a falling edge and an acknowledge write fall in the same clock cycle, the latch ends that cycle set.
- R9: `cpu_irq` equals latch AND NOT mask. The pending flag shows the latch whatever the mask setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when the register is not read |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
A falling edge detected by the pin path and an acknowledge write from the bus can land on the same clock edge. They then drive the latch in opposite directions.

The bench provokes this by sweeping the delay between the pin's falling edge and the acknowledge write over five offsets. One of those offsets places the write exactly on the edge-detect cycle.

A behavioural model judges every cycle. It keeps a queue of pin samples and gives the set condition precedence over the clear. A design that lets the acknowledge win drops a request, and the model flags the mismatch on the pending bit and on `cpu_irq`.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;

    localparam int REG_W    = 8;
    localparam int PEND_BIT = 3;
    localparam int ACK_BIT  = 2;
    localparam int MASK_BIT = 1;
    localparam int MODE_BIT = 0;

    typedef enum logic {
        SENSE_EDGE  = 1'b0,
        SENSE_LEVEL = 1'b1
    } sense_e;

    typedef struct packed {
        logic   mask;
        sense_e mode;
    } ctrl_t;

    typedef struct packed {
        logic fall;
        logic low;
    } pin_ev_t;

    function automatic logic [REG_W-1:0] pack_status(input logic pend, input ctrl_t c);
        logic [REG_W-1:0] v;
        v           = '0;
        v[PEND_BIT] = pend;
        v[MASK_BIT] = c.mask;
        v[MODE_BIT] = c.mode;
        return v;
    endfunction

    function automatic logic set_cond(input pin_ev_t ev, input sense_e mode);
        return ev.fall || (mode == SENSE_LEVEL && ev.low);
    endfunction

endpackage

// File: rtl/eip_sync.sv
`timescale 1ns/1ps
module eip_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{IDLE}};
                else     chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{IDLE}};
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/eip_edge.sv
`timescale 1ns/1ps
module eip_edge
    import ext_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pin_s,
    output pin_ev_t ev
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= pin_s;
    end

    always_comb begin
        ev.fall = prev_q && !pin_s;
        ev.low  = !pin_s;
    end

    a_r4_fall_from_high: assert property (@(posedge clk) disable iff (rst)
        ev.fall |=> !ev.fall);
endmodule

// File: rtl/eip_latch.sv
`timescale 1ns/1ps
module eip_latch
    import ext_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pin_ev_t ev,
    input  sense_e  mode,
    input  logic    ack,
    output logic    latch_q
);
    logic set_now;

    always_comb set_now = set_cond(ev, mode);

    always_ff @(posedge clk) begin
        if (rst)          latch_q <= 1'b0;
        else if (set_now) latch_q <= 1'b1;
        else if (ack)     latch_q <= 1'b0;
    end

    a_r5_edge_sets: assert property (@(posedge clk) disable iff (rst)
        ev.fall |=> latch_q);

    a_r7_level_holds: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_LEVEL && ev.low) |=> latch_q);

    a_r8_edge_beats_ack: assert property (@(posedge clk) disable iff (rst)
        (ack && ev.fall) |=> latch_q);

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !ev.fall && !(mode == SENSE_LEVEL && ev.low)) |=> !latch_q);

    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_q) |-> $past(ev.fall || (mode == SENSE_LEVEL && ev.low)));
endmodule

// File: rtl/eip_regs.sv
`timescale 1ns/1ps
module eip_regs
    import ext_irq_pkg::*;
#(
    parameter int              ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              pend,
    output ctrl_t             ctrl,
    output logic              ack
);
    logic sel, wr_sel;

    always_comb begin
        sel    = (bus_addr == REG_ADDR);
        wr_sel = sel && bus_wr;
        ack    = wr_sel && bus_wdata[ACK_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.mask <= 1'b0;
            ctrl.mode <= SENSE_EDGE;
        end else if (wr_sel) begin
            ctrl.mask <= bus_wdata[MASK_BIT];
            ctrl.mode <= sense_e'(bus_wdata[MODE_BIT]);
        end
    end

    always_comb begin
        if (bus_rd && sel) bus_rdata = pack_status(pend, ctrl);
        else               bus_rdata = '0;
    end

    a_r3_mask_follows_write: assert property (@(posedge clk) disable iff (rst)
        wr_sel |=> ctrl.mask == $past(bus_wdata[MASK_BIT]));

    a_r3_ctrl_holds_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_sel |=> $stable(ctrl));
endmodule

// File: rtl/ext_irq_ctrl.sv
`timescale 1ns/1ps
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_pin_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cpu_irq
);
    logic    pin_s;
    pin_ev_t ev;
    ctrl_t   ctrl;
    logic    ack;
    logic    latch_q;

    eip_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk(clk), .rst(rst), .din(irq_pin_n), .dout(pin_s)
    );

    eip_edge u_edge (
        .clk(clk), .rst(rst), .pin_s(pin_s), .ev(ev)
    );

    eip_latch u_latch (
        .clk(clk), .rst(rst), .ev(ev), .mode(ctrl.mode), .ack(ack), .latch_q(latch_q)
    );

    eip_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend(latch_q), .ctrl(ctrl), .ack(ack)
    );

    assign cpu_irq = latch_q && !ctrl.mask;

    a_r9_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        ctrl.mask |-> !cpu_irq);

    a_r2_ack_reads_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> !bus_rdata[ACK_BIT]);

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> bus_rdata[7:4] == 4'h0);
endmodule

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;
    localparam int         ADDR_W = 4;
    localparam logic [3:0] REG    = 4'h0;
    localparam logic [3:0] OTHER  = 4'h3;
    localparam int         LIMIT  = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin = 1'b1;
    logic [3:0] addr = REG;
    logic       wr = 1'b0;
    logic       rd = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    done   = 0;
    bit    seen   = 0;
    string phase  = "R1 reset";

    int hq[$] = '{1, 1, 1};
    bit m_latch = 0, m_mask = 0, m_mode = 0;

    always #2 clk = ~clk;

    ext_irq_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG)) i_ext_irq_ctrl (
        .clk(clk), .rst(rst), .irq_pin_n(pin),
        .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .cpu_irq(irq)
    );

    always @(posedge clk) begin
        seen = 1;
        if (rst) begin
            hq = '{1, 1, 1};
            m_latch = 0; m_mask = 0; m_mode = 0;
        end else begin
            bit fall, low, set, sel, ack;
            fall = hq[2] == 1 && hq[1] == 0;
            low  = hq[1] == 0;
            set  = fall || (m_mode && low);
            sel  = wr && addr == REG;
            ack  = sel && wdata[2];
            if (set)      m_latch = 1;
            else if (ack) m_latch = 0;
            if (sel) begin
                m_mask = wdata[1];
                m_mode = wdata[0];
            end
            hq.push_front(int'(pin));
            void'(hq.pop_back());
        end
    end

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s): actual=%h expected=%h at %0t", phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (seen && !done) begin
            logic [7:0] exp_rd;
            exp_rd = (rd && addr == REG) ? {4'b0, m_latch, 1'b0, m_mask, m_mode} : 8'h00;
            chk("read data", rdata, exp_rd);
            chk("cpu_irq", {7'b0, irq}, {7'b0, m_latch && !m_mask});
        end
    end

    task automatic summary;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= LIMIT && !done) begin
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, LIMIT);
            summary();
        end
    end

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic wr_reg(input logic [7:0] v);
        addr = REG; wdata = v; wr = 1'b1;
        tick();
        wr = 1'b0; wdata = 8'h00;
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(3);

        phase = "R2 read layout and select";
        rd = 1'b0; idle(2);
        rd = 1'b1; addr = OTHER; idle(2);
        addr = REG; idle(1);

        phase = "R3 control write";
        wr_reg(8'hF3); idle(2);
        wr_reg(8'h02); wr_reg(8'h00); idle(2);
        addr = OTHER; wr = 1'b1; wdata = 8'h03; tick(); wr = 1'b0; addr = REG; idle(2);

        phase = "R4 sync and edge";
        pin = 1'b0; idle(6);

        phase = "R5 edge-only ack with pin low";
        wr_reg(8'h04); idle(6);
        pin = 1'b1; idle(4);

        phase = "R6 ack bit";
        pin = 1'b0; idle(1); pin = 1'b1; idle(5);
        wr_reg(8'h00); idle(2);
        wr_reg(8'h04); idle(3);

        phase = "R7 level mode";
        wr_reg(8'h01);
        pin = 1'b0; idle(5);
        wr_reg(8'h05); idle(3);
        pin = 1'b1; idle(4);
        wr_reg(8'h05); idle(3);
        pin = 1'b0; idle(1); pin = 1'b1; idle(5);
        wr_reg(8'h05); idle(2);
        wr_reg(8'h00); idle(2);

        phase = "R8 edge and ack same cycle";
        for (int off = 0; off < 5; off++) begin
            pin = 1'b1; idle(4);
            wr_reg(8'h04);
            pin = 1'b0; idle(off);
            wr_reg(8'h04); idle(3);
            pin = 1'b1; idle(3);
            wr_reg(8'h04); idle(1);
        end

        phase = "R9 masking";
        wr_reg(8'h02);
        pin = 1'b0; idle(4); pin = 1'b1; idle(3);
        wr_reg(8'h00); idle(2);
        wr_reg(8'h06); idle(2);
        wr_reg(8'h00); idle(2);

        summary();
    end
endmodule